// File: doc/BRIEF.md
# Virtual Processor Suspend/Resume Controller

This block coordinates a group of virtual processors (VPs) that share one core complex. Each VP owns a one-bit suspend-others flag. Any VP can issue a decoded "suspend others" or "resume others" strobe. The block applies the operation and returns the VP's control word from before the operation as the instruction result. It also emits single-cycle halt or wake pulses toward the other VPs.

The flags drive two combinational outputs per VP:
- an active indication;
- a has-work indication, which combines a base work flag from the core with a wake interrupt request.

A read port returns either a VP's control word or its fixed global number. Reads are accepted only while the VP-support flag in the configuration word is set.

Several VPs can issue strobes in the same cycle. A fixed-priority arbiter, lowest index first, serialises them at one per cycle. A strobe that has not yet been granted stays pending inside the block. A new strobe from a VP that already has one pending is dropped. If a VP raises both strobes in the same cycle, the suspend is taken.

Top module: `vp_gate_ctrl`

## Requirements
- R1: After reset, every suspend flag is clear. All VPs are active, and no result, halt pulse or wake pulse is raised.
- R2: Suspend by a VP whose flag is clear works as follows. The cycle after the strobe, it reports `res_valid` with `res_vp` set to the issuer and `res_data` bit 0 = 0. In that same cycle, it pulses `halt_pulse` for every other VP. It then sets the issuer's flag.
- R3: Suspend by a VP whose flag is already set reports `res_data` bit 0 = 1. It raises no pulse and changes no state.
- R4: Resume by a VP whose flag is set reports bit 0 = 1 and clears the flag. It pulses `wake_pulse` for every other VP except one that is both halted (`vp_wfi`) and active at the moment of the operation.
- R5: Resume by a VP whose flag is clear reports bit 0 = 0. It raises no pulse and changes no state.
- R6: A VP is active when its own flag is set, or when no other VP has its flag set.
- R7: While support is on, `has_work` follows these rules. It is 1 when the VP is active and either `base_work` or `wake_irq` is set. It is 0 for an inactive VP even if `wake_irq` is set.
- R8: A read of register 2, select 1 returns the VP's index in bits 7:0, with all other bits zero. This value is fixed from reset.
- R9: A read of register 0, select 4 returns the VP's current flag in bit 0, with all other bits zero.
- R10: While bit 7 of `cfg_word` is clear, the following holds. Strobes are discarded and produce no result or pulse, including after support returns. Every read reports `rd_unimpl` = 1 with data 0. `has_work` equals `base_work`.
- R11: Requests pending in the same cycle are granted lowest index first, one per cycle, with one result per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | DATA_W | Configuration word; bit 7 enables VP support |
| dvp_req | input | NUM_VP | Per-VP suspend-others strobe |
| evp_req | input | NUM_VP | Per-VP resume-others strobe |
| vp_wfi | input | NUM_VP | Per-VP halted-in-wait state |
| wake_irq | input | NUM_VP | Per-VP pending wake interrupt |
| base_work | input | NUM_VP | Per-VP work flag from the core |
| rd_en | input | 1 | Read request |
| rd_vp | input | IDX_W | VP addressed by the read |
| rd_reg | input | 5 | Register number of the read |
| rd_sel | input | 3 | Select of the read |
| rd_data | output | DATA_W | Read data |
| rd_unimpl | output | 1 | Read hit no implemented register |
| res_valid | output | 1 | Operation result valid |
| res_vp | output | IDX_W | VP that receives the result |
| res_data | output | DATA_W | Control word before the operation |
| halt_pulse | output | NUM_VP | One-cycle halt request per VP |
| wake_pulse | output | NUM_VP | One-cycle wake request per VP |
| vp_active | output | NUM_VP | Per-VP active state |
| has_work | output | NUM_VP | Per-VP has-work state |

## Verification
A wrong flag bit becomes visible at the ports in the same cycle. It flips `vp_active` of that VP or of every other VP combinationally, and it changes `has_work` for any VP with a pending wake interrupt. A flag that updates late or wrongly shows up on the next operation. That operation returns the wrong bit 0 in its result, one cycle after its strobe, and sends halt or wake pulses that should not occur, or omits them. Arbitration faults appear as results arriving in the wrong VP order within the cycles after a burst of simultaneous strobes.

// File: rtl/vp_gate_pkg.sv
package vp_gate_pkg;
  typedef enum logic {
    OP_SUSPEND = 1'b0,
    OP_RESUME  = 1'b1
  } vp_op_e;

  localparam int SUPPORT_BIT = 7;
  localparam logic [4:0] CTL_REG  = 5'd0;
  localparam logic [2:0] CTL_SEL  = 3'd4;
  localparam logic [4:0] GNUM_REG = 5'd2;
  localparam logic [2:0] GNUM_SEL = 3'd1;
  localparam int GNUM_W = 8;
endpackage

// File: rtl/vp_prio_arb.sv
module vp_prio_arb #(
  parameter int NUM_VP = 4,
  localparam int IDX_W = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input  logic [NUM_VP-1:0] req,
  output logic [NUM_VP-1:0] grant,
  output logic [IDX_W-1:0]  grant_idx,
  output logic              grant_any
);
  always_comb begin
    grant     = '0;
    grant_idx = '0;
    grant_any = 1'b0;
    for (int i = NUM_VP - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant     = '0;
        grant[i]  = 1'b1;
        grant_idx = IDX_W'(i);
        grant_any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vp_op_sched.sv
module vp_op_sched
  import vp_gate_pkg::*;
#(
  parameter int NUM_VP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              support,
  input  logic [NUM_VP-1:0] dvp_req,
  input  logic [NUM_VP-1:0] evp_req,
  input  logic [NUM_VP-1:0] grant,
  output logic [NUM_VP-1:0] req_vec,
  output logic [NUM_VP-1:0] kind_vec
);
  logic [NUM_VP-1:0] pend_q, pend_d;
  logic [NUM_VP-1:0] kind_q, kind_d;
  logic [NUM_VP-1:0] fresh;

  always_comb begin
    fresh = (dvp_req | evp_req) & ~pend_q & {NUM_VP{support}};
    for (int i = 0; i < NUM_VP; i++) begin
      if (pend_q[i]) kind_vec[i] = kind_q[i];
      else           kind_vec[i] = dvp_req[i] ? OP_SUSPEND : OP_RESUME;
    end
    req_vec = (pend_q | fresh) & {NUM_VP{support}};
    pend_d  = req_vec & ~grant;
    kind_d  = kind_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      kind_q <= '0;
    end else begin
      pend_q <= pend_d;
      kind_q <= kind_d;
    end
  end
endmodule

// File: rtl/vp_flag_state.sv
module vp_flag_state
  import vp_gate_pkg::*;
#(
  parameter int NUM_VP = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec,
  input  logic [NUM_VP-1:0] grant,
  input  logic [IDX_W-1:0]  grant_idx,
  input  logic              grant_kind,
  input  logic [NUM_VP-1:0] vp_wfi,
  input  logic [NUM_VP-1:0] active,
  output logic [NUM_VP-1:0] flags,
  output logic              res_valid,
  output logic [IDX_W-1:0]  res_vp,
  output logic [DATA_W-1:0] res_data,
  output logic [NUM_VP-1:0] halt_pulse,
  output logic [NUM_VP-1:0] wake_pulse
);
  logic [NUM_VP-1:0] flag_q, flag_d;
  logic              rv_q, rv_d;
  logic [IDX_W-1:0]  rvp_q, rvp_d;
  logic              rbit_q, rbit_d;
  logic [NUM_VP-1:0] halt_q, halt_d, wake_q, wake_d;
  logic              own_flag;

  always_comb begin
    own_flag = flag_q[grant_idx];
    flag_d   = flag_q;
    rv_d     = exec;
    rvp_d    = exec ? grant_idx : rvp_q;
    rbit_d   = exec ? own_flag : rbit_q;
    halt_d   = '0;
    wake_d   = '0;
    if (exec) begin
      if (vp_op_e'(grant_kind) == OP_SUSPEND) begin
        if (!own_flag) begin
          halt_d = ~grant;
          flag_d = flag_q | grant;
        end
      end else if (own_flag) begin
        wake_d = ~grant & ~(vp_wfi & active);
        flag_d = flag_q & ~grant;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      rv_q   <= 1'b0;
      rvp_q  <= '0;
      rbit_q <= 1'b0;
      halt_q <= '0;
      wake_q <= '0;
    end else begin
      flag_q <= flag_d;
      rv_q   <= rv_d;
      rvp_q  <= rvp_d;
      rbit_q <= rbit_d;
      halt_q <= halt_d;
      wake_q <= wake_d;
    end
  end

  assign flags      = flag_q;
  assign res_valid  = rv_q;
  assign res_vp     = rvp_q;
  assign res_data   = {{(DATA_W-1){1'b0}}, rbit_q};
  assign halt_pulse = halt_q;
  assign wake_pulse = wake_q;
endmodule

// File: rtl/vp_status.sv
module vp_status #(
  parameter int NUM_VP = 4
) (
  input  logic              support,
  input  logic [NUM_VP-1:0] flags,
  input  logic [NUM_VP-1:0] wake_irq,
  input  logic [NUM_VP-1:0] base_work,
  output logic [NUM_VP-1:0] active,
  output logic [NUM_VP-1:0] has_work
);
  for (genvar i = 0; i < NUM_VP; i++) begin : g_vp
    logic [NUM_VP-1:0] others;
    always_comb begin
      others    = flags;
      others[i] = 1'b0;
      active[i] = flags[i] | ~(|others);
      if (support) has_work[i] = (base_work[i] | wake_irq[i]) & active[i];
      else         has_work[i] = base_work[i];
    end
  end
endmodule

// File: rtl/vp_read_port.sv
module vp_read_port
  import vp_gate_pkg::*;
#(
  parameter int NUM_VP = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              support,
  input  logic [NUM_VP-1:0] flags,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_vp,
  input  logic [4:0]        rd_reg,
  input  logic [2:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_unimpl
);
  logic [GNUM_W-1:0] gnum_q [NUM_VP];

  for (genvar i = 0; i < NUM_VP; i++) begin : g_gnum
    logic [GNUM_W-1:0] gnum_d;
    assign gnum_d = gnum_q[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gnum_q[i] <= GNUM_W'(i);
      else        gnum_q[i] <= gnum_d;
    end
  end

  logic vp_ok, hit_ctl, hit_gnum;

  always_comb begin
    vp_ok    = int'(rd_vp) < NUM_VP;
    hit_ctl  = support && vp_ok && rd_reg == CTL_REG  && rd_sel == CTL_SEL;
    hit_gnum = support && vp_ok && rd_reg == GNUM_REG && rd_sel == GNUM_SEL;
    rd_data  = '0;
    if (rd_en && hit_ctl)  rd_data[0] = flags[rd_vp];
    if (rd_en && hit_gnum) rd_data[GNUM_W-1:0] = gnum_q[rd_vp];
    rd_unimpl = rd_en && !(hit_ctl || hit_gnum);
  end
endmodule

// File: rtl/vp_gate_ctrl.sv
module vp_gate_ctrl
  import vp_gate_pkg::*;
#(
  parameter int NUM_VP = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cfg_word,
  input  logic [NUM_VP-1:0] dvp_req,
  input  logic [NUM_VP-1:0] evp_req,
  input  logic [NUM_VP-1:0] vp_wfi,
  input  logic [NUM_VP-1:0] wake_irq,
  input  logic [NUM_VP-1:0] base_work,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_vp,
  input  logic [4:0]        rd_reg,
  input  logic [2:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_unimpl,
  output logic              res_valid,
  output logic [IDX_W-1:0]  res_vp,
  output logic [DATA_W-1:0] res_data,
  output logic [NUM_VP-1:0] halt_pulse,
  output logic [NUM_VP-1:0] wake_pulse,
  output logic [NUM_VP-1:0] vp_active,
  output logic [NUM_VP-1:0] has_work
);
  logic              support;
  logic [NUM_VP-1:0] req_vec, kind_vec, grant, flags;
  logic [IDX_W-1:0]  grant_idx;
  logic              grant_any;

  assign support = cfg_word[SUPPORT_BIT];

  vp_op_sched #(.NUM_VP(NUM_VP)) u_sched (
    .clk(clk), .rst_n(rst_n), .support(support),
    .dvp_req(dvp_req), .evp_req(evp_req), .grant(grant),
    .req_vec(req_vec), .kind_vec(kind_vec)
  );

  vp_prio_arb #(.NUM_VP(NUM_VP)) u_arb (
    .req(req_vec), .grant(grant), .grant_idx(grant_idx), .grant_any(grant_any)
  );

  vp_flag_state #(.NUM_VP(NUM_VP), .DATA_W(DATA_W)) u_state (
    .clk(clk), .rst_n(rst_n), .exec(grant_any), .grant(grant),
    .grant_idx(grant_idx), .grant_kind(kind_vec[grant_idx]),
    .vp_wfi(vp_wfi), .active(vp_active), .flags(flags),
    .res_valid(res_valid), .res_vp(res_vp), .res_data(res_data),
    .halt_pulse(halt_pulse), .wake_pulse(wake_pulse)
  );

  vp_status #(.NUM_VP(NUM_VP)) u_status (
    .support(support), .flags(flags), .wake_irq(wake_irq),
    .base_work(base_work), .active(vp_active), .has_work(has_work)
  );

  vp_read_port #(.NUM_VP(NUM_VP), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .support(support), .flags(flags),
    .rd_en(rd_en), .rd_vp(rd_vp), .rd_reg(rd_reg), .rd_sel(rd_sel),
    .rd_data(rd_data), .rd_unimpl(rd_unimpl)
  );
endmodule

// File: rtl/vp_gate_chk.sv
module vp_gate_chk #(
  parameter int NUM_VP = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] cfg_word,
  input logic [NUM_VP-1:0] wake_irq,
  input logic              res_valid,
  input logic [IDX_W-1:0]  res_vp,
  input logic [DATA_W-1:0] res_data,
  input logic [NUM_VP-1:0] halt_pulse,
  input logic [NUM_VP-1:0] wake_pulse,
  input logic [NUM_VP-1:0] vp_active,
  input logic [NUM_VP-1:0] has_work
);
  // R10
  no_result_unsupported_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_word[7] |=> !res_valid);

  // R2
  halt_needs_clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|halt_pulse) |-> (res_valid && !res_data[0] && !halt_pulse[res_vp]));

  // R4
  wake_needs_set_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wake_pulse) |-> (res_valid && res_data[0] && !wake_pulse[res_vp]));

  // R3
  no_halt_and_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|halt_pulse) |-> !(|wake_pulse));

  // R7
  inactive_no_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_word[7] |-> ((has_work & ~vp_active) == '0));

  // R6
  some_vp_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vp_active != '0);
endmodule

bind vp_gate_ctrl vp_gate_chk #(.NUM_VP(NUM_VP), .DATA_W(DATA_W)) u_vp_gate_chk (.*);

// File: tb/test_vp_gate_ctrl.sv
module test_vp_gate_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int W = 32;

  logic clk, rst_n;
  logic [W-1:0] cfg_word;
  logic [N-1:0] dvp_req, evp_req, vp_wfi, wake_irq, base_work;
  logic rd_en;
  logic [1:0] rd_vp;
  logic [4:0] rd_reg;
  logic [2:0] rd_sel;
  logic [W-1:0] rd_data, res_data;
  logic rd_unimpl, res_valid;
  logic [1:0] res_vp;
  logic [N-1:0] halt_pulse, wake_pulse, vp_active, has_work;

  vp_gate_ctrl #(.NUM_VP(N), .DATA_W(W)) i_vp_gate_ctrl (.*);

  int checks = 0, failures = 0;
  bit done = 0;

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0] dvp, evp, wfi;
    logic       val;
    logic [1:0] vp;
    logic       bit0;
    logic [3:0] halt, wake, act;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{4'b0100, 4'b0000, 4'b0000, 1'b1, 2'd2, 1'b0, 4'b1011, 4'b0000, 4'b0100}, // R2
    '{4'b0000, 4'b0000, 4'b0000, 1'b0, 2'd0, 1'b0, 4'b0000, 4'b0000, 4'b0100}, // R6
    '{4'b0100, 4'b0000, 4'b0000, 1'b1, 2'd2, 1'b1, 4'b0000, 4'b0000, 4'b0100}, // R3
    '{4'b0000, 4'b0100, 4'b0001, 1'b1, 2'd2, 1'b1, 4'b0000, 4'b1011, 4'b1111}, // R4
    '{4'b0000, 4'b0010, 4'b0000, 1'b1, 2'd1, 1'b0, 4'b0000, 4'b0000, 4'b1111}, // R5
    '{4'b0001, 4'b0000, 4'b0000, 1'b1, 2'd0, 1'b0, 4'b1110, 4'b0000, 4'b0001}, // R2
    '{4'b1000, 4'b0000, 4'b0000, 1'b1, 2'd3, 1'b0, 4'b0111, 4'b0000, 4'b1001}, // R6
    '{4'b0000, 4'b0001, 4'b1000, 1'b1, 2'd0, 1'b1, 4'b0000, 4'b0110, 4'b1000}, // R4
    '{4'b0000, 4'b1000, 4'b0000, 1'b1, 2'd3, 1'b1, 4'b0000, 4'b0111, 4'b1111}  // R4
  };

  task automatic op(input logic [3:0] d, input logic [3:0] e);
    dvp_req = d; evp_req = e;
    @(negedge clk);
    dvp_req = '0; evp_req = '0;
  endtask

  task automatic expect_res(input string req, input logic [1:0] vp, input logic b,
                            input logic [3:0] h, input logic [3:0] w);
    chk({req, " valid"}, 32'(res_valid), 32'd1);
    chk({req, " vp"}, 32'(res_vp), 32'(vp));
    chk({req, " data"}, res_data, 32'(b));
    chk({req, " halt"}, 32'(halt_pulse), 32'(h));
    chk({req, " wake"}, 32'(wake_pulse), 32'(w));
  endtask

  task automatic rd(input logic [1:0] vp, input logic [4:0] r, input logic [2:0] s);
    rd_en = 1; rd_vp = vp; rd_reg = r; rd_sel = s;
    #1;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_word = 32'h80; dvp_req = 0; evp_req = 0; vp_wfi = 0;
    wake_irq = 0; base_work = 0; rd_en = 0; rd_vp = 0; rd_reg = 0; rd_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 active", 32'(vp_active), 32'hF);
    chk("R1 valid", 32'(res_valid), 0);
    chk("R1 pulses", 32'({halt_pulse, wake_pulse}), 0);

    // Vector table
    for (int k = 0; k < 9; k++) begin
      vp_wfi = VECS[k].wfi;
      op(VECS[k].dvp, VECS[k].evp);
      chk($sformatf("R2-5 row%0d valid", k), 32'(res_valid), 32'(VECS[k].val));
      if (VECS[k].val) begin
        chk($sformatf("R2-5 row%0d vp", k), 32'(res_vp), 32'(VECS[k].vp));
        chk($sformatf("R2-5 row%0d data", k), res_data, 32'(VECS[k].bit0));
      end
      chk($sformatf("R2 row%0d halt", k), 32'(halt_pulse), 32'(VECS[k].halt));
      chk($sformatf("R4 row%0d wake", k), 32'(wake_pulse), 32'(VECS[k].wake));
      chk($sformatf("R6 row%0d active", k), 32'(vp_active), 32'(VECS[k].act));
    end
    vp_wfi = 0;

    // R11 arbitration: VP1,VP2 suspend and VP3 resume together
    op(4'b0110, 4'b1000);
    expect_res("R11 first", 2'd1, 1'b0, 4'b1101, 4'b0000);
    @(negedge clk);
    expect_res("R11 second", 2'd2, 1'b0, 4'b1011, 4'b0000);
    @(negedge clk);
    expect_res("R11 third", 2'd3, 1'b0, 4'b0000, 4'b0000);
    @(negedge clk);
    chk("R11 drained", 32'(res_valid), 0);
    op(4'b0000, 4'b0010);
    expect_res("R4 cleanup1", 2'd1, 1'b1, 4'b0000, 4'b1101);
    op(4'b0000, 4'b0100);
    expect_res("R4 cleanup2", 2'd2, 1'b1, 4'b0000, 4'b1011);
    chk("R6 all active", 32'(vp_active), 32'hF);

    // R7 has-work
    wake_irq = 4'b0010;
    #1 chk("R7 wake irq", 32'(has_work), 32'h2);
    op(4'b0001, 4'b0000);
    base_work = 4'b0011;
    #1 chk("R7 inactive masked", 32'(has_work), 32'h1);

    // R9 / R8 reads
    rd(2'd0, 5'd0, 3'd4); chk("R9 ctl vp0", rd_data, 1); chk("R9 unimpl", 32'(rd_unimpl), 0);
    rd(2'd1, 5'd0, 3'd4); chk("R9 ctl vp1", rd_data, 0);
    rd(2'd3, 5'd2, 3'd1); chk("R8 gnum vp3", rd_data, 3); chk("R8 unimpl", 32'(rd_unimpl), 0);
    rd(2'd2, 5'd2, 3'd1); chk("R8 gnum vp2", rd_data, 2);
    rd(2'd2, 5'd2, 3'd0); chk("R9 other addr unimpl", 32'(rd_unimpl), 1);
    rd_en = 0;
    @(negedge clk);
    op(4'b0000, 4'b0001);
    expect_res("R4 cleanup3", 2'd0, 1'b1, 4'b0000, 4'b1110);

    // R10 support off
    cfg_word = 32'h0;
    base_work = 4'b0100; wake_irq = 4'b1111;
    #1 chk("R10 has_work", 32'(has_work), 32'h4);
    rd(2'd3, 5'd2, 3'd1);
    chk("R10 rd unimpl", 32'(rd_unimpl), 1);
    chk("R10 rd data", rd_data, 0);
    rd_en = 0;
    @(negedge clk);
    op(4'b0001, 4'b0000);
    chk("R10 no result", 32'(res_valid), 0);
    chk("R10 no halt", 32'(halt_pulse), 0);
    cfg_word = 32'h80;
    @(negedge clk);
    chk("R10 no late result", 32'(res_valid), 0);
    chk("R10 flags untouched", 32'(vp_active), 32'hF);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule